// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, once per clock, whether the processor takes an exception or returns from one, and produces every status and control write that goes with that choice. Seven request lines come in: reset request, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. The block applies the two interrupt masks held in the current status word and picks the highest-priority request that remains. It then emits the new status word, the value and target mode of the saved-status write, the link write, and the vector address for the program counter.

When no request is live and the return strobe is high, the block restores the status word from the saved copy and loads the program counter from the link value. All outputs are registered, so results appear one clock after the inputs are sampled. Register storage and instruction decode stay outside the block. The surrounding core supplies the current status, the saved status of the current mode, the link value and the return address.

Status word layout: flags at bits 31:28, interrupt mask I at bit 7, fast-interrupt mask F at bit 6, instruction-state bit T at bit 5, and mode at bits 4:0.

Top module: `trap_sequencer`

## Requirements
- R1: While `rst` is high, every write strobe and every data output is cleared at the next clock edge.
- R2: When several unmasked requests are high together, the one taken follows this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: A normal interrupt request is ignored while bit 7 of `cur_psr` is 1, and a fast interrupt request is ignored while bit 6 is 1. An ignored request alone causes no write.
- R4: The target mode codes on entry are: reset and software interrupt 5'b10011, undefined instruction 5'b11011, both aborts 5'b10111, normal interrupt 5'b10010, fast interrupt 5'b10001. On entry, `tgt_mode` and `spsr_mode` carry this code.
- R5: The vector is the table base plus a cause offset. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. The base is 0x00000000, or 0xFFFF0000 when `hivec` is 1. Offset 0x14 is never produced.
- R6: The new status on entry equals `cur_psr` with these changes: bits 4:0 set to the target mode, bit 5 cleared, bit 7 set, and bit 6 set for reset and fast interrupt only. All other bits are kept.
- R7: On entry, `spsr_we`, `lr_we`, `psr_we` and `pc_we` pulse together. `spsr_out` equals the sampled `cur_psr`, and `lr_out` equals the sampled `ret_addr`.
- R8: With no live request, a high `ret_strobe` raises `psr_we` and `pc_we` only. It gives `psr_out` = `saved_psr`, `pc_out` = `link_addr`, and `tgt_mode` = bits 4:0 of `saved_psr`.
- R9: A live request in the same cycle as `ret_strobe` wins, and the return is dropped.
- R10: Outputs change one clock after their inputs are sampled. With no live request and no return strobe, all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| hivec | input | 1 | Selects the high vector table base |
| ret_strobe | input | 1 | Handler return request |
| cur_psr | input | 32 | Current status word |
| saved_psr | input | 32 | Saved status of the current mode |
| ret_addr | input | 32 | Return address for entry |
| link_addr | input | 32 | Link value used on return |
| psr_we | output | 1 | Status word write |
| psr_out | output | 32 | New status word |
| spsr_we | output | 1 | Saved-status write |
| spsr_out | output | 32 | Saved-status write data |
| spsr_mode | output | 5 | Mode whose saved status is written |
| lr_we | output | 1 | Link write |
| lr_out | output | 32 | Link write data |
| tgt_mode | output | 5 | Mode in force after the action |
| pc_we | output | 1 | Program counter write |
| pc_out | output | 32 | Vector or return address |

## Verification
On every cycle, the checker enforces several rules. Reset clears the strobes. A masked interrupt alone causes no write. The entry strobes rise together with T cleared and I set. Vectors stay word aligned and never land on the reserved slot. A lone return strobe reloads the status and program counter from the sampled saved values. The full priority order, the exact mode codes, the base selected by `hivec`, and the selective setting of F depend on which mix of requests arrives together. Only the bench scenarios show these: directed single requests, contested pairs, and seeded random mixes compared against a bench model.

// File: rtl/trap_pkg.sv
package trap_pkg;

  parameter int unsigned XLEN   = 32;
  parameter int unsigned MODE_W = 5;
  parameter int unsigned NCAUSE = 8;

  // Status word bit positions
  localparam int unsigned T_POS = 5;
  localparam int unsigned F_POS = 6;
  localparam int unsigned I_POS = 7;

  // Cause index equals the vector slot number (offset = index * 4)
  typedef enum logic [2:0] {
    CS_RESET = 3'd0,
    CS_UNDEF = 3'd1,
    CS_SWI   = 3'd2,
    CS_PABT  = 3'd3,
    CS_DABT  = 3'd4,
    CS_RSVD  = 3'd5,
    CS_IRQ   = 3'd6,
    CS_FIQ   = 3'd7
  } cause_e;

  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;

  function automatic logic [MODE_W-1:0] mode_of(cause_e c);
    case (c)
      CS_FIQ:           return MD_FIQ;
      CS_IRQ:           return MD_IRQ;
      CS_PABT, CS_DABT: return MD_ABT;
      CS_UNDEF:         return MD_UND;
      default:          return MD_SVC;
    endcase
  endfunction

  function automatic logic sets_fmask(cause_e c);
    return (c == CS_RESET) || (c == CS_FIQ);
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned N = NCAUSE
) (
  input  logic [N-1:0] req,
  input  logic         irq_mask,
  input  logic         fiq_mask,
  output logic         hit,
  output cause_e       sel
);
  localparam int unsigned NPRIO = 7;
  // Highest priority first
  localparam logic [2:0] PRIO [0:NPRIO-1] = '{3'd0, 3'd4, 3'd7, 3'd6, 3'd3, 3'd1, 3'd2};

  logic [N-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mask
      if (g == int'(CS_IRQ)) begin : g_irq
        assign live[g] = req[g] & ~irq_mask;
      end else if (g == int'(CS_FIQ)) begin : g_fiq
        assign live[g] = req[g] & ~fiq_mask;
      end else if (g == int'(CS_RSVD)) begin : g_rsv
        assign live[g] = 1'b0;
      end else begin : g_pass
        assign live[g] = req[g];
      end
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    sel = CS_RESET;
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (live[PRIO[i]]) begin
        hit = 1'b1;
        sel = cause_e'(PRIO[i]);
      end
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter logic [W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  cause_e       sel,
  input  logic         hivec,
  output logic [W-1:0] vec
);
  localparam int unsigned SLOT_SHIFT = 2;
  logic [W-1:0] base;
  logic [W-1:0] offs;

  assign base = hivec ? HI_BASE : '0;
  assign offs = W'(sel) << SLOT_SHIFT;
  assign vec  = base | offs;
endmodule

// File: rtl/trap_psr_build.sv
module trap_psr_build
  import trap_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0]      cur,
  input  cause_e            sel,
  output logic [W-1:0]      nxt,
  output logic [MODE_W-1:0] mode
);
  always_comb begin
    mode = mode_of(sel);
    nxt  = cur;
    nxt[MODE_W-1:0] = mode;
    nxt[T_POS] = 1'b0;
    nxt[I_POS] = 1'b1;
    if (sets_fmask(sel)) nxt[F_POS] = 1'b1;
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int unsigned  W = XLEN,
  parameter logic [W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic              hivec,
  input  logic              ret_strobe,
  input  logic [W-1:0]      cur_psr,
  input  logic [W-1:0]      saved_psr,
  input  logic [W-1:0]      ret_addr,
  input  logic [W-1:0]      link_addr,
  output logic              psr_we,
  output logic [W-1:0]      psr_out,
  output logic              spsr_we,
  output logic [W-1:0]      spsr_out,
  output logic [MODE_W-1:0] spsr_mode,
  output logic              lr_we,
  output logic [W-1:0]      lr_out,
  output logic [MODE_W-1:0] tgt_mode,
  output logic              pc_we,
  output logic [W-1:0]      pc_out
);
  logic [NCAUSE-1:0] req_vec;
  logic              hit;
  cause_e            sel;
  logic [W-1:0]      vec;
  logic [W-1:0]      ent_psr;
  logic [MODE_W-1:0] ent_mode;
  logic              do_ret;

  always_comb begin
    req_vec = '0;
    req_vec[CS_RESET] = req_reset;
    req_vec[CS_UNDEF] = req_undef;
    req_vec[CS_SWI]   = req_swi;
    req_vec[CS_PABT]  = req_pabt;
    req_vec[CS_DABT]  = req_dabt;
    req_vec[CS_IRQ]   = req_irq;
    req_vec[CS_FIQ]   = req_fiq;
  end

  trap_arbiter #(.N(NCAUSE)) u_arb (
    .req      (req_vec),
    .irq_mask (cur_psr[I_POS]),
    .fiq_mask (cur_psr[F_POS]),
    .hit      (hit),
    .sel      (sel)
  );

  trap_vector #(.W(W), .HI_BASE(HI_BASE)) u_vec (
    .sel   (sel),
    .hivec (hivec),
    .vec   (vec)
  );

  trap_psr_build #(.W(W)) u_psr (
    .cur  (cur_psr),
    .sel  (sel),
    .nxt  (ent_psr),
    .mode (ent_mode)
  );

  assign do_ret = ret_strobe & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_we    <= 1'b0;
      spsr_we   <= 1'b0;
      lr_we     <= 1'b0;
      pc_we     <= 1'b0;
      psr_out   <= '0;
      spsr_out  <= '0;
      spsr_mode <= '0;
      lr_out    <= '0;
      tgt_mode  <= '0;
      pc_out    <= '0;
    end else begin
      psr_we  <= hit | do_ret;
      pc_we   <= hit | do_ret;
      spsr_we <= hit;
      lr_we   <= hit;
      if (hit) begin
        psr_out   <= ent_psr;
        spsr_out  <= cur_psr;
        spsr_mode <= ent_mode;
        lr_out    <= ret_addr;
        tgt_mode  <= ent_mode;
        pc_out    <= vec;
      end else if (do_ret) begin
        psr_out  <= saved_psr;
        tgt_mode <= saved_psr[MODE_W-1:0];
        pc_out   <= link_addr;
      end
    end
  end
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
  import trap_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input logic              clk,
  input logic              rst,
  input logic              req_reset,
  input logic              req_undef,
  input logic              req_swi,
  input logic              req_pabt,
  input logic              req_dabt,
  input logic              req_irq,
  input logic              req_fiq,
  input logic              ret_strobe,
  input logic [W-1:0]      cur_psr,
  input logic [W-1:0]      saved_psr,
  input logic [W-1:0]      link_addr,
  input logic              psr_we,
  input logic [W-1:0]      psr_out,
  input logic              spsr_we,
  input logic              lr_we,
  input logic              pc_we,
  input logic [W-1:0]      pc_out
);
  logic others;
  assign others = req_reset | req_undef | req_swi | req_pabt | req_dabt;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!psr_we && !spsr_we && !lr_we && !pc_we));

  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_irq && cur_psr[7] && !others && !req_fiq && !ret_strobe) |=> !psr_we);

  // R3
  fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_fiq && cur_psr[6] && !others && !req_irq && !ret_strobe) |=> !psr_we);

  // R6
  entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
    spsr_we |-> (!psr_out[5] && psr_out[7]));

  // R7
  entry_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    spsr_we |-> (lr_we && psr_we && pc_we));

  // R5
  vector_slot_chk: assert property (@(posedge clk) disable iff (rst)
    spsr_we |-> (pc_out[1:0] == 2'b00 && pc_out[4:2] != 3'd5));

  // R8
  return_path_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && !others && !(req_irq && !cur_psr[7]) && !(req_fiq && !cur_psr[6]))
      |=> (psr_we && pc_we && !spsr_we && !lr_we &&
           psr_out == $past(saved_psr) && pc_out == $past(link_addr)));
endmodule

bind trap_sequencer trap_sequencer_chk #(.W(W)) u_chk (.*);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;
  logic clk = 1'b0;
  logic rst;
  logic req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq;
  logic hivec, ret_strobe;
  logic [31:0] cur_psr, saved_psr, ret_addr, link_addr;
  logic psr_we, spsr_we, lr_we, pc_we;
  logic [31:0] psr_out, spsr_out, lr_out, pc_out;
  logic [4:0] spsr_mode, tgt_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_sequencer u0 (.*);

  // Expected values
  logic        e_entry, e_ret;
  logic [31:0] e_psr, e_pc;
  logic [4:0]  e_mode;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic predict();
    int c;
    c = -1;
    if (req_reset) c = 0;
    else if (req_dabt) c = 4;
    else if (req_fiq && !cur_psr[6]) c = 7;
    else if (req_irq && !cur_psr[7]) c = 6;
    else if (req_pabt) c = 3;
    else if (req_undef) c = 1;
    else if (req_swi) c = 2;
    e_entry = (c >= 0);
    e_ret   = !e_entry && ret_strobe;
    if (e_entry) begin
      case (c)
        0, 2: e_mode = 5'b10011;
        1:    e_mode = 5'b11011;
        3, 4: e_mode = 5'b10111;
        6:    e_mode = 5'b10010;
        default: e_mode = 5'b10001;
      endcase
      e_psr = cur_psr;
      e_psr[4:0] = e_mode;
      e_psr[5] = 1'b0;
      e_psr[7] = 1'b1;
      if (c == 0 || c == 7) e_psr[6] = 1'b1;
      e_pc = (hivec ? 32'hFFFF_0000 : 32'h0) + 32'(c * 4);
    end else if (e_ret) begin
      e_psr  = saved_psr;
      e_mode = saved_psr[4:0];
      e_pc   = link_addr;
    end
  endtask

  // Drive at negedge, check one edge later at the following negedge (R10)
  task automatic step(input string tag);
    logic [31:0] s_psr, s_ret;
    predict();
    s_psr = cur_psr;
    s_ret = ret_addr;
    @(negedge clk);
    check({tag, " R10 psr_we"}, 32'(psr_we), 32'(e_entry | e_ret));
    check({tag, " R7 spsr_we"}, 32'(spsr_we), 32'(e_entry));
    check({tag, " R7 lr_we"}, 32'(lr_we), 32'(e_entry));
    check({tag, " R10 pc_we"}, 32'(pc_we), 32'(e_entry | e_ret));
    if (e_entry) begin
      check({tag, " R6 psr"}, psr_out, e_psr);
      check({tag, " R5 vector"}, pc_out, e_pc);
      check({tag, " R4 mode"}, 32'(tgt_mode), 32'(e_mode));
      check({tag, " R4 spsr_mode"}, 32'(spsr_mode), 32'(e_mode));
      check({tag, " R7 spsr"}, spsr_out, s_psr);
      check({tag, " R7 lr"}, lr_out, s_ret);
    end else if (e_ret) begin
      check({tag, " R8 psr"}, psr_out, e_psr);
      check({tag, " R8 pc"}, pc_out, e_pc);
      check({tag, " R8 mode"}, 32'(tgt_mode), 32'(e_mode));
    end
  endtask

  task automatic clear_req();
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
    ret_strobe = 1'b0;
  endtask

  task automatic one_req(input int idx);
    clear_req();
    case (idx)
      0: req_reset = 1'b1;
      1: req_undef = 1'b1;
      2: req_swi   = 1'b1;
      3: req_pabt  = 1'b1;
      4: req_dabt  = 1'b1;
      6: req_irq   = 1'b1;
      default: req_fiq = 1'b1;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_req();
    hivec = 0; cur_psr = 32'h0; saved_psr = 32'h0; ret_addr = 32'h0; link_addr = 32'h0;
    rst = 1'b1;
    req_reset = 1'b1; ret_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 psr_we", 32'(psr_we), 0);
    check("R1 spsr_we", 32'(spsr_we), 0);
    check("R1 pc_we", 32'(pc_we), 0);
    check("R1 pc_out", pc_out, 0);
    check("R1 psr_out", psr_out, 0);
    rst = 1'b0;
    clear_req();
    step("idle");

    // R4 R5 R6: each cause alone, both bases
    for (int hv = 0; hv < 2; hv++) begin
      foreach (u0.req_vec[k]) begin
        if (k != 5) begin
          one_req(k);
          hivec = hv[0];
          cur_psr = 32'hA000_0030;
          ret_addr = 32'h1000 + 32'(k);
          step("single");
        end
      end
    end

    // R3 masked interrupts alone
    one_req(6); cur_psr = 32'h0000_0090; step("R3 irq masked");
    one_req(7); cur_psr = 32'h0000_0050; step("R3 fiq masked");
    // R2 contested pairs
    one_req(7); req_irq = 1; cur_psr = 32'h0000_0010; step("R2 fiq>irq");
    one_req(4); req_fiq = 1; step("R2 dabt>fiq");
    one_req(3); req_undef = 1; req_swi = 1; step("R2 pabt>undef");
    one_req(6); req_pabt = 1; step("R2 irq>pabt");
    one_req(1); req_swi = 1; step("R2 undef>swi");
    // R8 return alone, R9 return with request
    clear_req(); ret_strobe = 1; saved_psr = 32'h6000_00D3; link_addr = 32'h0000_8004;
    step("R8 return");
    one_req(2); ret_strobe = 1; step("R9 swi wins");
    one_req(6); ret_strobe = 1; cur_psr = 32'h0000_0080; step("R9 masked irq lets return");

    // Random mixes
    for (int it = 0; it < 400; it++) begin
      req_reset  = ($urandom % 16) == 0;
      req_undef  = ($urandom % 6) == 0;
      req_swi    = ($urandom % 6) == 0;
      req_pabt   = ($urandom % 6) == 0;
      req_dabt   = ($urandom % 8) == 0;
      req_irq    = ($urandom % 3) == 0;
      req_fiq    = ($urandom % 3) == 0;
      ret_strobe = ($urandom % 3) == 0;
      hivec      = $urandom % 2;
      cur_psr    = $urandom;
      saved_psr  = $urandom;
      ret_addr   = $urandom;
      link_addr  = $urandom;
      step("R2 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule